// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block lets the two ports of a shared memory signal each other. The two highest locations of the address space act as mailboxes. The left port posts to the right port by writing the topmost address. The right port posts to the left port by writing the address just below it. Each post drives the interrupt flag of the receiving port low. The receiving port takes the message by reading its incoming mailbox, and that read releases its flag.

The block watches only the address, chip select, write strobe and read strobe of each port. The memory array stores the mailbox data words. Each flag is a registered, active-low output, so it can drive an interrupt line directly. The address width is a parameter. Both mailbox addresses are derived from it: all ones, and all ones minus one.

Top module: `dpmbx_irq`

## Requirements
- R1: A left-port write (select=1, write=1) to address all-ones drives `irq_r_n` low on the clock edge that samples the write.
- R2: A right-port read (select=1, read=1, write=0) of address all-ones drives `irq_r_n` high on the clock edge that samples the read.
- R3: A right-port write to address all-ones-minus-one drives `irq_l_n` low on the clock edge that samples the write.
- R4: A left-port read (select=1, read=1, write=0) of address all-ones-minus-one drives `irq_l_n` high on the clock edge that samples the read.
- R5: A write by the receiving port to its own incoming mailbox leaves its flag unchanged: a right write to all-ones does not release `irq_r_n`, and a left write to all-ones-minus-one does not release `irq_l_n`.
- R6: A flag does not change on any cycle without a post or take for it. This covers accesses with select=0, accesses to other addresses, and a port reading its own outgoing mailbox.
- R7: When a post and a take for the same flag fall in the same cycle, the post wins and the flag is driven low.
- R8: While `rst_n` is low at a clock edge, both flags are driven high, whatever the port activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_addr | input | AW | Left port address |
| l_sel | input | 1 | Left port chip select, active high |
| l_wr | input | 1 | Left port write strobe, active high |
| l_rd | input | 1 | Left port read strobe, active high |
| r_addr | input | AW | Right port address |
| r_sel | input | 1 | Right port chip select, active high |
| r_wr | input | 1 | Right port write strobe, active high |
| r_rd | input | 1 | Right port read strobe, active high |
| irq_l_n | output | 1 | Interrupt flag toward the left port, active low |
| irq_r_n | output | 1 | Interrupt flag toward the right port, active low |

## Verification
Each flag passes through exactly one register. A post or take presented before a rising edge therefore shows on the flag just after that edge, with no further latency. The bench drives each vector's strobes on a falling edge and compares the flags at the next falling edge, one rising edge later. Strobes and compare both sit half a period away from the active edge. The reset check applies the same one-edge rule.

// File: rtl/dpmbx_pkg.sv
// Shared types for the dual-port mailbox interrupt logic.
// Assumes: nothing beyond a synthesizable SystemVerilog flow.
package dpmbx_pkg;

    // Port index: 0 = left, 1 = right
    localparam int unsigned NUM_SIDES = 2;

    // Mailbox events decoded from one port's access in one cycle
    typedef struct packed {
        logic post;   // write to the outgoing mailbox
        logic take;   // read of the incoming mailbox
    } mbx_evt_t;

endpackage

// File: rtl/mbx_port_decode.sv
// Decodes one port's strobes into mailbox events.
// Assumes: strobes are active high and qualified by the select.
// A cycle with both write and read set counts as a write.
module mbx_port_decode
    import dpmbx_pkg::*;
#(
    parameter int unsigned    AW       = 13,
    parameter logic [AW-1:0]  OUT_ADDR = '1,
    parameter logic [AW-1:0]  IN_ADDR  = '0
) (
    input  logic [AW-1:0] addr,
    input  logic          sel,
    input  logic          wr,
    input  logic          rd,
    output mbx_evt_t      evt
);

    // Match the address against both mailboxes and qualify with the strobes
    always_comb begin
        evt.post = sel && wr && (addr == OUT_ADDR);
        evt.take = sel && rd && !wr && (addr == IN_ADDR);
    end

endmodule

// File: rtl/mbx_irq_flag.sv
// One active-low interrupt flag. A set has priority over a clear.
// Assumes: synchronous active-low reset, one clock domain.
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    // Hold the flag; reset releases it, set asserts it, clear releases it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (set) begin
            irq_n <= 1'b0;
        end else if (clr) begin
            irq_n <= 1'b1;
        end
    end

endmodule

// File: rtl/dpmbx_irq.sv
// Top of the mailbox interrupt logic. The left port posts to the right port
// through the top address, and the right port posts to the left port through
// the address just below it.
// Assumes: both ports share clk. The mailbox data words live in the memory array.
module dpmbx_irq
    import dpmbx_pkg::*;
#(
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] l_addr,
    input  logic          l_sel,
    input  logic          l_wr,
    input  logic          l_rd,
    input  logic [AW-1:0] r_addr,
    input  logic          r_sel,
    input  logic          r_wr,
    input  logic          r_rd,
    output logic          irq_l_n,
    output logic          irq_r_n
);

    localparam logic [AW-1:0] ADDR_HI = '1;
    localparam logic [AW-1:0] ADDR_LO = ADDR_HI - 1'b1;

    logic [AW-1:0] addr_s [NUM_SIDES];
    logic          sel_s  [NUM_SIDES];
    logic          wr_s   [NUM_SIDES];
    logic          rd_s   [NUM_SIDES];
    mbx_evt_t      evt_s  [NUM_SIDES];
    logic          irq_s  [NUM_SIDES];

    // Gather the port signals into per-side arrays
    always_comb begin
        addr_s[0] = l_addr;  sel_s[0] = l_sel;  wr_s[0] = l_wr;  rd_s[0] = l_rd;
        addr_s[1] = r_addr;  sel_s[1] = r_sel;  wr_s[1] = r_wr;  rd_s[1] = r_rd;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        // Left posts to HI and takes from LO; the right port is the mirror
        mbx_port_decode #(
            .AW       (AW),
            .OUT_ADDR ((s == 0) ? ADDR_HI : ADDR_LO),
            .IN_ADDR  ((s == 0) ? ADDR_LO : ADDR_HI)
        ) u_dec (
            .addr (addr_s[s]),
            .sel  (sel_s[s]),
            .wr   (wr_s[s]),
            .rd   (rd_s[s]),
            .evt  (evt_s[s])
        );

        // The flag of this side is set by the other side's post
        mbx_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (evt_s[NUM_SIDES-1-s].post),
            .clr   (evt_s[s].take),
            .irq_n (irq_s[s])
        );
    end

    assign irq_l_n = irq_s[0];
    assign irq_r_n = irq_s[1];

endmodule

// File: rtl/dpmbx_irq_chk.sv
// Checker for dpmbx_irq. It decodes the port strobes on its own and relates
// them to the flag outputs one edge later.
// Assumes: attached by the bind at the end of this file.
module dpmbx_irq_chk #(
    parameter int unsigned AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] l_addr,
    input logic          l_sel,
    input logic          l_wr,
    input logic          l_rd,
    input logic [AW-1:0] r_addr,
    input logic          r_sel,
    input logic          r_wr,
    input logic          r_rd,
    input logic          irq_l_n,
    input logic          irq_r_n
);

    localparam logic [AW-1:0] HI = '1;
    localparam logic [AW-1:0] LO = HI - 1'b1;

    logic set_r, clr_r, set_l, clr_l;
    // Reference decode of the four mailbox events
    always_comb begin
        set_r = l_sel && l_wr && (l_addr == HI);
        clr_r = r_sel && r_rd && !r_wr && (r_addr == HI);
        set_l = r_sel && r_wr && (r_addr == LO);
        clr_l = l_sel && l_rd && !l_wr && (l_addr == LO);
    end

    AST_SET_RIGHT:  assert property (@(posedge clk) disable iff (!rst_n) set_r |=> !irq_r_n);                     // R1
    AST_CLR_RIGHT:  assert property (@(posedge clk) disable iff (!rst_n) (clr_r && !set_r) |=> irq_r_n);          // R2
    AST_SET_LEFT:   assert property (@(posedge clk) disable iff (!rst_n) set_l |=> !irq_l_n);                     // R3
    AST_CLR_LEFT:   assert property (@(posedge clk) disable iff (!rst_n) (clr_l && !set_l) |=> irq_l_n);          // R4
    AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) (!set_r && !clr_r) |=> $stable(irq_r_n)); // R6
    AST_HOLD_LEFT:  assert property (@(posedge clk) disable iff (!rst_n) (!set_l && !clr_l) |=> $stable(irq_l_n)); // R6
    AST_SET_WINS:   assert property (@(posedge clk) disable iff (!rst_n) (set_r && clr_r) |=> !irq_r_n);          // R7
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (irq_l_n && irq_r_n));                             // R8

endmodule

bind dpmbx_irq dpmbx_irq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dpmbx_irq.sv
`timescale 1ns/1ps
// Bench for dpmbx_irq: walks a vector table, then runs directed reset tests.
module sim_dpmbx_irq;

    localparam int unsigned AW = 13;
    localparam logic [AW-1:0] HI = 13'h1FFF;
    localparam logic [AW-1:0] LO = 13'h1FFE;

    typedef struct packed {
        logic [AW-1:0] la;
        logic          lsel, lwr, lrd;
        logic [AW-1:0] ra;
        logic          rsel, rwr, rrd;
        logic          exp_l, exp_r;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{13'h0000,1'b0,1'b0,1'b0, 13'h0000,1'b0,1'b0,1'b0, 1'b1,1'b1, 8'd6}, // R6 idle
        '{HI,      1'b1,1'b1,1'b0, 13'h0000,1'b0,1'b0,1'b0, 1'b1,1'b0, 8'd1}, // R1 left posts
        '{HI,      1'b1,1'b0,1'b1, 13'h0000,1'b0,1'b0,1'b0, 1'b1,1'b0, 8'd6}, // R6 sender reads outgoing
        '{13'h0000,1'b0,1'b0,1'b0, HI,      1'b1,1'b1,1'b0, 1'b1,1'b0, 8'd5}, // R5 right writes own box
        '{13'h0000,1'b0,1'b0,1'b0, HI,      1'b0,1'b0,1'b1, 1'b1,1'b0, 8'd6}, // R6 read without select
        '{13'h0000,1'b0,1'b0,1'b0, HI,      1'b1,1'b0,1'b1, 1'b1,1'b1, 8'd2}, // R2 right takes
        '{13'h0000,1'b0,1'b0,1'b0, LO,      1'b1,1'b1,1'b0, 1'b0,1'b1, 8'd3}, // R3 right posts
        '{LO,      1'b1,1'b1,1'b0, 13'h0000,1'b0,1'b0,1'b0, 1'b0,1'b1, 8'd5}, // R5 left writes own box
        '{13'h0123,1'b1,1'b0,1'b1, 13'h0000,1'b0,1'b0,1'b0, 1'b0,1'b1, 8'd6}, // R6 other address
        '{LO,      1'b1,1'b0,1'b1, 13'h0000,1'b0,1'b0,1'b0, 1'b1,1'b1, 8'd4}, // R4 left takes
        '{HI,      1'b1,1'b1,1'b0, HI,      1'b1,1'b0,1'b1, 1'b1,1'b0, 8'd7}, // R7 post+take, flag idle
        '{13'h0000,1'b0,1'b0,1'b0, HI,      1'b1,1'b0,1'b1, 1'b1,1'b1, 8'd2}, // R2 take again
        '{HI,      1'b1,1'b1,1'b0, LO,      1'b1,1'b1,1'b0, 1'b0,1'b0, 8'd3}, // R1 and R3 together
        '{LO,      1'b1,1'b0,1'b1, HI,      1'b1,1'b0,1'b1, 1'b1,1'b1, 8'd4}, // R4 and R2 together
        '{HI,      1'b1,1'b1,1'b0, 13'h0000,1'b0,1'b0,1'b0, 1'b1,1'b0, 8'd1}, // R1 post
        '{HI,      1'b1,1'b1,1'b0, HI,      1'b1,1'b0,1'b1, 1'b1,1'b0, 8'd7}, // R7 post+take, flag set
        '{13'h0000,1'b0,1'b0,1'b0, HI,      1'b1,1'b0,1'b1, 1'b1,1'b1, 8'd2}  // R2 final take
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_sel = 1'b0, l_wr = 1'b0, l_rd = 1'b0;
    logic          r_sel = 1'b0, r_wr = 1'b0, r_rd = 1'b0;
    logic          irq_l_n, irq_r_n;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    dpmbx_irq #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd),
        .r_addr(r_addr), .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd),
        .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
    );

    task automatic check(input int req, input logic el, input logic er, input string what);
        n_chk++;
        if (irq_l_n !== el || irq_r_n !== er) begin
            n_bad++;
            $display("FAIL R%0d %s: irq_l_n/irq_r_n actual %b%b expected %b%b",
                     req, what, irq_l_n, irq_r_n, el, er);
        end
    endtask

    task automatic drive(input vec_t v);
        l_addr = v.la; l_sel = v.lsel; l_wr = v.lwr; l_rd = v.lrd;
        r_addr = v.ra; r_sel = v.rsel; r_wr = v.rwr; r_rd = v.rrd;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(8, 1'b1, 1'b1, "reset state");            // R8
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            check(int'(VEC[i].req), VEC[i].exp_l, VEC[i].exp_r, $sformatf("vector %0d", i));
        end
        // Directed: set both flags, then reset with a post still driven (R8)
        @(negedge clk);
        drive('{HI,1'b1,1'b1,1'b0, LO,1'b1,1'b1,1'b0, 1'b0,1'b0,8'd1});
        @(negedge clk);
        check(3, 1'b0, 1'b0, "both set before reset"); // R3
        rst_n = 1'b0;
        @(negedge clk);
        check(8, 1'b1, 1'b1, "reset overrides post");  // R8
        drive('{13'h0000,1'b0,1'b0,1'b0, 13'h0000,1'b0,1'b0,1'b0, 1'b1,1'b1,8'd0});
        rst_n = 1'b1;
        @(negedge clk);
        check(6, 1'b1, 1'b1, "idle after reset");       // R6
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule